// File: doc/BRIEF.md
# Serial-Access Sectored Flash Array

This block is a synthesizable behavioural model of a small on-chip non-volatile store: 512 words of 16 bits, split into two equal sectors by the top address bit. The array cannot be reached in parallel from outside. Software-side logic steers it through two serial registers. The address register either shifts in one bit or counts up by one on each of its clock strobes. The data register either shifts one bit through, or loads the addressed word in parallel, on each of its clock strobes.

A rising edge on the program request writes the data register into the addressed word. Programming can only clear bits: the new data is ANDed into the stored word. A rising edge on the erase request sets every word of the addressed sector back to all ones. Both operations are timed internally by parameterised counters, and `busy` is high while one runs. An oscillator output runs at a quarter of the core clock rate when it is enabled, or while an external real-time reprogramming indicator is high. In every other case it stays low.

The address and data clocks, the program request and the erase request are all sampled on the core clock `clk` and edge-detected there. Each strobe acts on the core clock edge at which its rising level is first seen.

Top module: `sflash_array`

## Requirements
- R1: While `rst_n` is low and after its release, `busy`, `op_clash`, `osc_out` and `data_sout` are 0, and the address register holds 0.
- R2: On a rising `addr_clk` with `addr_shift` high, the address register shifts left and takes `addr_sin` into bit 0, so a 9-bit address is entered MSB first.
- R3: On a rising `addr_clk` with `addr_shift` low, the address register adds one, and 1FFh wraps to 000h.
- R4: On a rising `data_clk` with `data_shift` high, the data register shifts left and takes `data_sin` into bit 0. `data_sout` always shows bit 15, so a word is read and written MSB first.
- R5: On a rising `data_clk` with `data_shift` low, the data register loads the word at the current address.
- R6: A program operation stores (old word AND data register). A 1 in the data register never turns a stored 0 into 1.
- R7: An erase operation sets all 256 words of the sector chosen by address bit 8 (0 for 000h–0FFh, 1 for 100h–1FFh) to FFFFh. The other sector is unchanged.
- R8: After a rising `prog_req` (or `erase_req`) is seen at a clock edge, `busy` is high for exactly PROG_CYC (or ERASE_CYC) following clock cycles. The change to the array takes effect as `busy` falls.
- R9: A rising `prog_req` or `erase_req` that arrives while `busy` is high has no effect: no cycle is started or extended, and the array does not change.
- R10: If `prog_req` and `erase_req` rise on the same edge while idle, `op_clash` is high for exactly one cycle, `busy` stays low, and the array does not change.
- R11: With `osc_en` and `rtr_active` both low, `osc_out` is 0 from the next edge onward. With either one high, `osc_out` toggles every two clock cycles, giving a period of four cycles.
- R12: `rtr_active` high runs the oscillator even when `osc_en` is low.
- R13: Only edges start operations. A `prog_req` held high after its cycle ends does not start another cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; also the undivided oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_clk | input | 1 | Address register strobe (rising edge acts) |
| addr_shift | input | 1 | 1: shift address, 0: increment |
| addr_sin | input | 1 | Serial address input |
| data_clk | input | 1 | Data register strobe (rising edge acts) |
| data_shift | input | 1 | 1: shift data, 0: load addressed word |
| data_sin | input | 1 | Serial data input |
| data_sout | output | 1 | Data register MSB |
| prog_req | input | 1 | Program request (rising edge) |
| erase_req | input | 1 | Sector erase request (rising edge) |
| busy | output | 1 | Program or erase cycle in progress |
| op_clash | output | 1 | One-cycle flag: program and erase rose together |
| osc_en | input | 1 | Oscillator enable |
| rtr_active | input | 1 | Real-time reprogramming active; forces oscillator on |
| osc_out | output | 1 | Oscillator output, clk divided by four |

## Verification
Every strobe passes through one edge-detect register, so a shift, an increment or a load driven at a falling edge is visible on `data_sout` at the next falling edge. `busy` and `op_clash` rise at that same first edge. The bench drives each input at a falling edge and samples at the next one. It counts the falling edges on which `busy` reads high and compares that count with PROG_CYC or ERASE_CYC exactly. The read-back of stored words happens only after `busy` has dropped, which is when the array update lands. The oscillator is sampled on consecutive falling edges and compared two and four samples apart.

// File: rtl/sflash_pkg.sv
package sflash_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2
  } op_e;
endpackage

// File: rtl/sflash_edge.sv
module sflash_edge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    assign rise[g] = lvl[g] & ~prev_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= lvl[g];
    end
  end
endmodule

// File: rtl/sflash_regs.sv
module sflash_regs #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_rise,
  input  logic              addr_shift,
  input  logic              addr_sin,
  input  logic              data_rise,
  input  logic              data_shift,
  input  logic              data_sin,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dreg
);
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] dreg_d;

  always_comb begin
    addr_d = addr;
    if (addr_rise) begin
      if (addr_shift) addr_d = {addr[ADDR_W-2:0], addr_sin};
      else            addr_d = addr + ADDR_W'(1);
    end
  end

  always_comb begin
    dreg_d = dreg;
    if (data_rise) begin
      if (data_shift) dreg_d = {dreg[DATA_W-2:0], data_sin};
      else            dreg_d = rd_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      dreg <= '0;
    end else begin
      addr <= addr_d;
      dreg <= dreg_d;
    end
  end
endmodule

// File: rtl/sflash_core.sv
module sflash_core
  import sflash_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 16,
  parameter int SECT_BITS = 1,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_rise,
  input  logic              erase_rise,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_word,
  output logic              busy,
  output logic              clash
);
  localparam int WORDS  = 1 << ADDR_W;
  localparam int OFF_W  = ADDR_W - SECT_BITS;
  localparam int MAXC   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W  = $clog2(MAXC + 1);

  op_e               st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] op_addr_q, op_addr_d;
  logic [DATA_W-1:0] op_data_q, op_data_d;
  logic              clash_d;
  logic              commit_prog, commit_erase;
  logic [SECT_BITS-1:0] op_sector;

  logic [DATA_W-1:0] mem [WORDS];

  assign op_sector = op_addr_q[ADDR_W-1 -: SECT_BITS];
  assign rd_word   = mem[addr];
  assign busy      = (st_q != OP_IDLE);

  always_comb begin
    st_d         = st_q;
    cnt_d        = cnt_q;
    op_addr_d    = op_addr_q;
    op_data_d    = op_data_q;
    clash_d      = 1'b0;
    commit_prog  = 1'b0;
    commit_erase = 1'b0;
    case (st_q)
      OP_IDLE: begin
        if (prog_rise && erase_rise) begin
          clash_d = 1'b1;
        end else if (prog_rise) begin
          st_d      = OP_PROG;
          cnt_d     = CNT_W'(PROG_CYC - 1);
          op_addr_d = addr;
          op_data_d = wdata;
        end else if (erase_rise) begin
          st_d      = OP_ERASE;
          cnt_d     = CNT_W'(ERASE_CYC - 1);
          op_addr_d = addr;
        end
      end
      default: begin
        if (cnt_q == '0) begin
          st_d         = OP_IDLE;
          commit_prog  = (st_q == OP_PROG);
          commit_erase = (st_q == OP_ERASE);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= OP_IDLE;
      cnt_q     <= '0;
      op_addr_q <= '0;
      op_data_q <= '0;
      clash     <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      op_addr_q <= op_addr_d;
      op_data_q <= op_data_d;
      clash     <= clash_d;
    end
  end

  // Array contents survive reset: it models a non-volatile store.
  always_ff @(posedge clk) begin
    if (commit_prog) begin
      mem[op_addr_q] <= mem[op_addr_q] & op_data_q;
    end
    if (commit_erase) begin
      for (int i = 0; i < WORDS; i++) begin
        if ((i >> OFF_W) == int'(op_sector)) mem[i] <= '1;
      end
    end
  end
endmodule

// File: rtl/sflash_osc.sv
module sflash_osc (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic osc_out
);
  logic phase_q, phase_d, osc_d;

  always_comb begin
    phase_d = 1'b0;
    osc_d   = 1'b0;
    if (run) begin
      phase_d = ~phase_q;
      osc_d   = phase_q ? ~osc_out : osc_out;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      osc_out <= 1'b0;
    end else begin
      phase_q <= phase_d;
      osc_out <= osc_d;
    end
  end
endmodule

// File: rtl/sflash_array.sv
module sflash_array #(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 16,
  parameter int SECT_BITS = 1,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_clk,
  input  logic addr_shift,
  input  logic addr_sin,
  input  logic data_clk,
  input  logic data_shift,
  input  logic data_sin,
  output logic data_sout,
  input  logic prog_req,
  input  logic erase_req,
  output logic busy,
  output logic op_clash,
  input  logic osc_en,
  input  logic rtr_active,
  output logic osc_out
);
  logic [3:0]        rise;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] dreg;
  logic [DATA_W-1:0] rd_word;

  sflash_edge #(.N(4)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  ({erase_req, prog_req, data_clk, addr_clk}),
    .rise (rise)
  );

  sflash_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_rise (rise[0]),
    .addr_shift(addr_shift),
    .addr_sin  (addr_sin),
    .data_rise (rise[1]),
    .data_shift(data_shift),
    .data_sin  (data_sin),
    .rd_word   (rd_word),
    .addr      (addr),
    .dreg      (dreg)
  );

  sflash_core #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_BITS(SECT_BITS),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_rise (rise[2]),
    .erase_rise(rise[3]),
    .addr      (addr),
    .wdata     (dreg),
    .rd_word   (rd_word),
    .busy      (busy),
    .clash     (op_clash)
  );

  sflash_osc u_osc (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (osc_en | rtr_active),
    .osc_out(osc_out)
  );

  assign data_sout = dreg[DATA_W-1];
endmodule

// File: rtl/sflash_array_chk.sv
module sflash_array_chk #(
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 20
) (
  input logic clk,
  input logic rst_n,
  input logic prog_req,
  input logic erase_req,
  input logic busy,
  input logic op_clash,
  input logic osc_en,
  input logic rtr_active,
  input logic osc_out
);
  localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int LW   = $clog2(MAXC + 2) + 1;

  logic [LW-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    len_q <= '0;
    else if (busy) len_q <= len_q + LW'(1);
    else           len_q <= '0;
  end

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (len_q == LW'(PROG_CYC) || len_q == LW'(ERASE_CYC))); // R8

  AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(prog_req) || $past(erase_req))); // R8

  AST_CLASH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_clash |-> (!busy && $past(prog_req) && $past(erase_req))); // R10

  AST_CLASH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    op_clash |=> !op_clash); // R10

  AST_OSC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !(osc_en || rtr_active) |=> !osc_out); // R11

  AST_OSC_HIGH2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(osc_out) && (osc_en || rtr_active)) |=> (osc_out || !(osc_en || rtr_active))); // R11
endmodule

bind sflash_array sflash_array_chk #(
  .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .prog_req  (prog_req),
  .erase_req (erase_req),
  .busy      (busy),
  .op_clash  (op_clash),
  .osc_en    (osc_en),
  .rtr_active(rtr_active),
  .osc_out   (osc_out)
);

// File: tb/sflash_array_test.sv
module sflash_array_test;
  localparam int CLK_PERIOD = 10;
  localparam int PCYC = 8;
  localparam int ECYC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_clk = 1'b0, addr_shift = 1'b0, addr_sin = 1'b0;
  logic data_clk = 1'b0, data_shift = 1'b0, data_sin = 1'b0;
  logic prog_req = 1'b0, erase_req = 1'b0;
  logic osc_en = 1'b0, rtr_active = 1'b0;
  logic data_sout, busy, op_clash, osc_out;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sflash_array #(.PROG_CYC(PCYC), .ERASE_CYC(ECYC)) uut (
    .clk(clk), .rst_n(rst_n),
    .addr_clk(addr_clk), .addr_shift(addr_shift), .addr_sin(addr_sin),
    .data_clk(data_clk), .data_shift(data_shift), .data_sin(data_sin),
    .data_sout(data_sout),
    .prog_req(prog_req), .erase_req(erase_req),
    .busy(busy), .op_clash(op_clash),
    .osc_en(osc_en), .rtr_active(rtr_active), .osc_out(osc_out)
  );

  // {address, first write, second write, expected word}
  localparam logic [56:0] VEC [6] = '{
    {9'h000, 16'hA5A5, 16'hFFFF, 16'hA5A5},
    {9'h0FF, 16'hFF00, 16'h0F0F, 16'h0F00},
    {9'h100, 16'h1234, 16'hFFFF, 16'h1234},
    {9'h1FF, 16'hFFFF, 16'hFFFF, 16'hFFFF},
    {9'h0AB, 16'h00FF, 16'hFFF0, 16'h00F0},
    {9'h155, 16'h8001, 16'h7FFF, 16'h0001}
  };

  task automatic step;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic addr_load(input logic [8:0] a);
    for (int i = 8; i >= 0; i--) begin
      addr_shift = 1'b1; addr_sin = a[i]; addr_clk = 1'b1; step;
      addr_clk = 1'b0; step;
    end
  endtask

  task automatic addr_inc;
    addr_shift = 1'b0; addr_clk = 1'b1; step;
    addr_clk = 1'b0; step;
  endtask

  task automatic data_load(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      data_shift = 1'b1; data_sin = w[i]; data_clk = 1'b1; step;
      data_clk = 1'b0; step;
    end
  endtask

  task automatic read_word(output logic [15:0] r);
    data_shift = 1'b0; data_clk = 1'b1; step;
    r[15] = data_sout;
    data_clk = 1'b0; step;
    for (int i = 14; i >= 0; i--) begin
      data_shift = 1'b1; data_sin = 1'b0; data_clk = 1'b1; step;
      r[i] = data_sout;
      data_clk = 1'b0; step;
    end
  endtask

  task automatic run_op(input bit is_erase, output int n);
    if (is_erase) erase_req = 1'b1; else prog_req = 1'b1;
    step;
    erase_req = 1'b0; prog_req = 1'b0;
    n = 0;
    while (busy && n < 1000) begin
      n++; step;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int n;
    logic [7:0] smp;

    step; step;
    // R1: outputs during reset
    check("R1 busy in reset", busy, 0);
    check("R1 osc in reset", osc_out, 0);
    rst_n = 1'b1;
    step;
    check("R1 busy", busy, 0);
    check("R1 clash", op_clash, 0);
    check("R1 sout", data_sout, 0);
    check("R1 osc", osc_out, 0);

    // R7: erase both sectors to get a known array
    addr_load(9'h000); run_op(1'b1, n); check("R7 erase s0 busy len (R8)", n, ECYC);
    addr_load(9'h100); run_op(1'b1, n); check("R7 erase s1 busy len (R8)", n, ECYC);
    addr_load(9'h042); read_word(rd); check("R7 erased word s0", rd, 16'hFFFF);

    // Table walk: R2 R4 R5 R6 R8
    for (int v = 0; v < 6; v++) begin
      addr_load(VEC[v][56:48]);
      data_load(VEC[v][47:32]);
      run_op(1'b0, n); check("R8 program busy len", n, PCYC);
      data_load(VEC[v][31:16]);
      run_op(1'b0, n); check("R8 program busy len", n, PCYC);
      read_word(rd);
      check("R6 stored AND of writes (R2 R4 R5)", rd, VEC[v][15:0]);
    end

    // R3: increment wraps 1FF -> 000
    addr_load(9'h1FF); addr_inc; read_word(rd);
    check("R3 wrap to word 0", rd, 16'hA5A5);
    addr_inc; read_word(rd);
    check("R3 increment to 001", rd, 16'hFFFF);

    // R9 + R7: program edge during erase of sector 1 is ignored
    addr_load(9'h155);
    data_load(16'h0000);
    erase_req = 1'b1; step; erase_req = 1'b0;
    n = 0;
    while (busy && n < 1000) begin
      n++;
      prog_req = (n == 3);
      step;
    end
    prog_req = 1'b0;
    check("R9 erase len unchanged", n, ECYC);
    step; step; step;
    check("R9 no new cycle", busy, 0);
    read_word(rd); check("R9 word not programmed / R7 erased", rd, 16'hFFFF);
    addr_load(9'h100); read_word(rd); check("R7 sector1 erased", rd, 16'hFFFF);
    addr_load(9'h0FF); read_word(rd); check("R7 sector0 kept", rd, 16'h0F00);

    // R10: simultaneous edges
    data_load(16'h0000);
    prog_req = 1'b1; erase_req = 1'b1; step;
    check("R10 clash flag", op_clash, 1);
    check("R10 busy stays low", busy, 0);
    prog_req = 1'b0; erase_req = 1'b0; step;
    check("R10 clash one cycle", op_clash, 0);
    check("R10 still idle", busy, 0);
    read_word(rd); check("R10 array unchanged", rd, 16'h0F00);

    // R13: held level does not retrigger
    addr_load(9'h0AB); data_load(16'h0000);
    prog_req = 1'b1; step;
    n = 0;
    while (busy && n < 1000) begin n++; step; end
    check("R13 first cycle len", n, PCYC);
    n = 0;
    for (int k = 0; k < 6; k++) begin
      if (busy) n++;
      step;
    end
    prog_req = 1'b0;
    check("R13 no retrigger", n, 0);
    read_word(rd); check("R13 single program applied", rd, 16'h0000);

    // R11: oscillator off then on
    n = 0;
    for (int k = 0; k < 8; k++) begin if (osc_out) n++; step; end
    check("R11 osc held low", n, 0);
    osc_en = 1'b1; step; step;
    for (int k = 0; k < 8; k++) begin smp[k] = osc_out; step; end
    n = 0;
    for (int k = 0; k < 4; k++) begin
      if (smp[k] !== smp[k+4]) n++;
      if (smp[k] === smp[k+2]) n++;
    end
    check("R11 period four", n, 0);
    osc_en = 1'b0; step; step;
    check("R11 osc off again", osc_out, 0);

    // R12: real-time reprogramming forces oscillator
    rtr_active = 1'b1; step; step;
    for (int k = 0; k < 8; k++) begin smp[k] = osc_out; step; end
    check("R12 osc runs with enable low", ($countones(smp) == 4), 1);
    rtr_active = 1'b0; step; step;
    check("R12 osc stops", osc_out, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule